// File: doc/BRIEF.md
# Mailbox Command Issue Engine

This block is a host-side hardware sequencer that hands one command at a time to a coprocessor through a memory-mapped mailbox and collects the outcome. A caller presents a command code, a direction flag (send or receive), an argument-present flag and four 32-bit argument words on a valid/ready request interface. The engine then drives a simple register master port. It waits for the coprocessor's command word to read idle and clears the status word. It writes the arguments when the command sends data and writes the command code. It rings the coprocessor through a separate interrupt-controller region and raises a one-cycle doorbell output.

Once the command is out, the engine waits for a rising edge on the completion interrupt input, bounded by a timeout of about 300 ms counted in clock cycles. It reads the status word and, for receive-type commands, reads the four argument words back. It then clears the status word again so that the coprocessor is released. The outcome is returned as a one-cycle response carrying a 3-bit error code and the argument words. Only one command is in flight at a time.

Error codes on `rsp_err`: 0 ok, 1 busy, 2 timeout, 3 invalid command, 4 not supported, 5 no map loaded, 6 map already set, 7 failure.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After accepting a request, the engine reads mailbox offset 0x00 repeatedly until it returns zero; if POLL_LIMIT (default 10000) reads all return non-zero, it responds with code 1 (busy) and performs no write at all.
- R2: The first write of every issued command is the value 0 to mailbox offset 0x04 (status), ahead of any argument or command write.
- R3: When both the send flag and the argument flag are set, exactly four writes follow the status clear, carrying argument words 0..3 to offsets 0x18, 0x1C, 0x20, 0x24 in that order; otherwise no argument write occurs.
- R4: The argument-offset function maps index 0..3 to 0x18 + 4*index and any index of 4 or more to 0x18.
- R5: The command code is written to mailbox offset 0x00, then 0x8000_0000 is written to offset 0x04 of the interrupt-controller region (select = 1); the doorbell output pulses for one cycle per command, in the cycle that write is acknowledged.
- R6: The completion catcher is cleared after the argument writes and before the command write, so a completion edge seen earlier (for example during the idle poll) does not end the wait.
- R7: If no completion edge arrives within the timeout window (TIMEOUT_MS at CLK_HZ, or SIM_TIMEOUT_CYC cycles when non-zero), or the status word read back is 0 or above 0xFF, the response is code 2 (timeout); in that case the status read is the last mailbox access and the status is not cleared.
- R8: After a valid status, a receive-type command with arguments reads offsets 0x18, 0x1C, 0x20, 0x24 in order and returns them as argument words 0..3 on `rsp_args`; every valid status is followed by a write of 0 to offset 0x04.
- R9: A valid status decodes as: 0xF0 to code 0, 0xF1 to 3, 0xF2 to 4, 0xF3 to 5, 0xF4 to 6, 0xFF to 7, and any other value from 0x01 to 0xFF to code 0.
- R10: `req_ready` is high only while idle, drops in the cycle after acceptance and stays low until `rsp_valid`, which is a single-cycle pulse followed by `req_ready` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Engine idle and able to accept |
| req_cmd | input | 8 | Command code |
| req_send | input | 1 | 1 = send-type, 0 = receive-type |
| req_has_args | input | 1 | Command carries argument words |
| req_args | input | 128 | Argument words, word k at bits 32k+31:32k |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 3 | Error code (see table above) |
| rsp_args | output | 128 | Argument words (read-back for receive-type) |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 0 = mailbox region, 1 = interrupt-controller region |
| bus_addr | output | 8 | Byte offset within the selected region |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid in this cycle |
| bus_rdata | input | 32 | Read data |
| doorbell | output | 1 | One-cycle wake pulse to the coprocessor |
| done_irq | input | 1 | Completion interrupt, synchronous, rising-edge sensitive |

## Verification
The assertions assume that `bus_ack` is only returned for an outstanding `bus_req` and never in two consecutive cycles, so that a request stays high and stable until its acknowledge. They also assume that `done_irq` is already synchronous to `clk`. The bench's coprocessor model acknowledges every access one cycle after it sees the request, drops the acknowledge for one cycle after each access, and drives the completion line from a clocked process. The bench changes requests only on the falling clock edge and only while the engine is idle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned NUM_ARGS = 4;
  localparam int unsigned ARG_W    = 32;
  localparam int unsigned OFS_W    = 8;

  localparam logic [OFS_W-1:0] OFS_CMD    = 8'h00;
  localparam logic [OFS_W-1:0] OFS_STAT   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_ARG0   = 8'h18;
  localparam logic [OFS_W-1:0] OFS_RING   = 8'h04;
  localparam logic [31:0]      RING_WORD  = 32'h8000_0000;

  typedef enum logic [2:0] {
    ERR_OK      = 3'd0,
    ERR_BUSY    = 3'd1,
    ERR_TIMEOUT = 3'd2,
    ERR_INVALID = 3'd3,
    ERR_NOSUPP  = 3'd4,
    ERR_NOMAP   = 3'd5,
    ERR_MAPSET  = 3'd6,
    ERR_FAIL    = 3'd7
  } mbx_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_CLR0, S_WRARG, S_ARM, S_WRCMD, S_RING,
    S_WAIT, S_RDST, S_RDARG, S_CLR1, S_RESP
  } mbx_state_e;

  // Argument slot offset; out-of-range indices fold back to slot 0.
  function automatic logic [OFS_W-1:0] arg_offset(input logic [2:0] idx);
    logic [OFS_W-1:0] slot;
    slot = (idx < 3'(NUM_ARGS)) ? {{(OFS_W-3){1'b0}}, idx} : '0;
    return OFS_ARG0 + (slot << 2);
  endfunction

  // Map a status word (plus the wait-expired flag) to an error code.
  function automatic mbx_err_e decode_status(input logic [31:0] st, input logic expired);
    mbx_err_e e;
    if (expired || st == 32'd0 || (|st[31:8])) begin
      e = ERR_TIMEOUT;
    end else begin
      case (st[7:0])
        8'hF1:   e = ERR_INVALID;
        8'hF2:   e = ERR_NOSUPP;
        8'hF3:   e = ERR_NOMAP;
        8'hF4:   e = ERR_MAPSET;
        8'hFF:   e = ERR_FAIL;
        default: e = ERR_OK;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/mbx_cycle_timer.sv
module mbx_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic hit
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step && !hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == W'(LIMIT));

  // R7 / R1: the count saturates at its limit and never wraps
  a_r7_timer_cap: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (hit || $past(clear)));

endmodule

// File: rtl/mbx_irq_catch.sv
module mbx_irq_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic arm,
  output logic seen,
  output logic rise
);
  logic irq_q;

  assign rise = irq & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      seen  <= 1'b0;
    end else begin
      irq_q <= irq;
      if (arm)       seen <= 1'b0;
      else if (rise) seen <= 1'b1;
    end
  end

  // R6: arming always leaves the catcher empty, even against a coincident edge
  a_r6_arm_discards: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !seen);

endmodule

// File: rtl/mbx_status_decode.sv
module mbx_status_decode
  import mbx_pkg::*;
(
  input  logic [31:0] status,
  input  logic        expired,
  output mbx_err_e    err,
  output logic        usable
);
  assign err    = decode_status(status, expired);
  assign usable = (err != ERR_TIMEOUT);
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter int unsigned CMD_W           = 8,
  parameter int unsigned CLK_HZ          = 200_000_000,
  parameter int unsigned TIMEOUT_MS      = 300,
  parameter int unsigned SIM_TIMEOUT_CYC = 0,
  parameter int unsigned POLL_LIMIT      = 10000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [CMD_W-1:0]          req_cmd,
  input  logic                      req_send,
  input  logic                      req_has_args,
  input  logic [NUM_ARGS*ARG_W-1:0] req_args,
  output logic                      rsp_valid,
  output logic [2:0]                rsp_err,
  output logic [NUM_ARGS*ARG_W-1:0] rsp_args,
  output logic                      bus_req,
  output logic                      bus_we,
  output logic                      bus_sel,
  output logic [OFS_W-1:0]          bus_addr,
  output logic [31:0]               bus_wdata,
  input  logic                      bus_ack,
  input  logic [31:0]               bus_rdata,
  output logic                      doorbell,
  input  logic                      done_irq
);
  localparam int unsigned TMO_CYC = (SIM_TIMEOUT_CYC != 0) ? SIM_TIMEOUT_CYC
                                                           : (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int unsigned IDX_W   = $clog2(NUM_ARGS);

  mbx_state_e           state;
  logic [IDX_W-1:0]     idx;
  logic                 send_q, has_q, expired_q, cmd_issued;
  logic [CMD_W-1:0]     cmd_q;
  mbx_err_e             err_q;
  logic [ARG_W-1:0]     arg_q [NUM_ARGS];

  // Named internal events
  logic      bus_done, poll_hit, wait_hit, done_seen, done_rise, arm;
  logic      last_idx, st_usable;
  mbx_err_e  st_err;

  assign bus_done = bus_req && bus_ack;
  assign last_idx = (idx == IDX_W'(NUM_ARGS - 1));
  assign arm      = (state == S_ARM);

  mbx_cycle_timer #(.LIMIT(POLL_LIMIT)) u_poll_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == S_IDLE),
    .step  ((state == S_POLL) && bus_done && (bus_rdata != 32'd0)),
    .hit   (poll_hit)
  );

  mbx_cycle_timer #(.LIMIT(TMO_CYC)) u_wait_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != S_WAIT),
    .step  (1'b1),
    .hit   (wait_hit)
  );

  mbx_irq_catch u_irq_catch (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (done_irq),
    .arm   (arm),
    .seen  (done_seen),
    .rise  (done_rise)
  );

  mbx_status_decode u_decode (
    .status  (bus_rdata),
    .expired (expired_q),
    .err     (st_err),
    .usable  (st_usable)
  );

  // Register-port drive, purely from state
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_sel   = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_POLL: begin
        bus_req  = !poll_hit;
        bus_addr = OFS_CMD;
      end
      S_CLR0, S_CLR1: begin
        bus_req  = 1'b1;
        bus_we   = 1'b1;
        bus_addr = OFS_STAT;
      end
      S_WRARG: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = arg_offset(3'(idx));
        bus_wdata = arg_q[idx];
      end
      S_WRCMD: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = OFS_CMD;
        bus_wdata = 32'(cmd_q);
      end
      S_RING: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_sel   = 1'b1;
        bus_addr  = OFS_RING;
        bus_wdata = RING_WORD;
      end
      S_RDST: begin
        bus_req  = 1'b1;
        bus_addr = OFS_STAT;
      end
      S_RDARG: begin
        bus_req  = 1'b1;
        bus_addr = arg_offset(3'(idx));
      end
      default: ;
    endcase
  end

  assign doorbell  = (state == S_RING) && bus_ack;
  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_err   = err_q;

  for (genvar k = 0; k < NUM_ARGS; k++) begin : g_rsp_pack
    assign rsp_args[k*ARG_W +: ARG_W] = arg_q[k];
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      send_q     <= 1'b0;
      has_q      <= 1'b0;
      expired_q  <= 1'b0;
      cmd_issued <= 1'b0;
      cmd_q      <= '0;
      err_q      <= ERR_OK;
      for (int k = 0; k < NUM_ARGS; k++) arg_q[k] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cmd_q      <= req_cmd;
            send_q     <= req_send;
            has_q      <= req_has_args;
            expired_q  <= 1'b0;
            cmd_issued <= 1'b0;
            for (int k = 0; k < NUM_ARGS; k++) arg_q[k] <= req_args[k*ARG_W +: ARG_W];
            state      <= S_POLL;
          end
        end
        S_POLL: begin
          if (poll_hit) begin
            err_q <= ERR_BUSY;
            state <= S_RESP;
          end else if (bus_done && bus_rdata == 32'd0) begin
            state <= S_CLR0;
          end
        end
        S_CLR0: begin
          if (bus_done) begin
            idx   <= '0;
            state <= (send_q && has_q) ? S_WRARG : S_ARM;
          end
        end
        S_WRARG: begin
          if (bus_done) begin
            idx   <= idx + 1'b1;
            state <= last_idx ? S_ARM : S_WRARG;
          end
        end
        S_ARM:   state <= S_WRCMD;
        S_WRCMD: begin
          if (bus_done) begin
            cmd_issued <= 1'b1;
            state      <= S_RING;
          end
        end
        S_RING:  if (bus_done) state <= S_WAIT;
        S_WAIT: begin
          if (done_seen) begin
            state <= S_RDST;
          end else if (wait_hit) begin
            expired_q <= 1'b1;
            state     <= S_RDST;
          end
        end
        S_RDST: begin
          if (bus_done) begin
            err_q <= st_err;
            idx   <= '0;
            if (!st_usable)               state <= S_RESP;
            else if (!send_q && has_q)    state <= S_RDARG;
            else                          state <= S_CLR1;
          end
        end
        S_RDARG: begin
          if (bus_done) begin
            arg_q[idx] <= bus_rdata;
            idx        <= idx + 1'b1;
            state      <= last_idx ? S_CLR1 : S_RDARG;
          end
        end
        S_CLR1:  if (bus_done) state <= S_RESP;
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: one request in flight
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R2 / R8: the only value ever written to the status word is zero
  a_r2_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_sel && bus_addr == OFS_STAT) |-> (bus_wdata == 32'd0));

  // R4: mailbox accesses never leave the argument range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_sel) |-> (bus_addr < (OFS_ARG0 + 8'(4 * NUM_ARGS))));

  // R5: doorbell only after the command write, and only for one cycle
  a_r5_ring_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> cmd_issued);
  a_r5_ring_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

  // R3: an access stays posted and unchanged until acknowledged
  a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

endmodule

// File: tb/mbx_cmd_engine_bench.sv
`timescale 1ns/1ps
module mbx_cmd_engine_bench;
  localparam int TMO    = 300;
  localparam int DELAY  = 20;
  localparam int PLIMIT = 10000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [7:0]   req_cmd = '0;
  logic         req_send = 1'b0;
  logic         req_has_args = 1'b0;
  logic [127:0] req_args = '0;
  logic         rsp_valid;
  logic [2:0]   rsp_err;
  logic [127:0] rsp_args;
  logic         bus_req, bus_we, bus_sel;
  logic [7:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic         bus_ack = 1'b0;
  logic [31:0]  bus_rdata = '0;
  logic         doorbell;
  logic         done_irq = 1'b0;

  always #2.5 clk = ~clk;

  mbx_cmd_engine #(.SIM_TIMEOUT_CYC(TMO), .POLL_LIMIT(PLIMIT)) u_mbx_cmd_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_send(req_send), .req_has_args(req_has_args), .req_args(req_args),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_args(rsp_args),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .doorbell(doorbell), .done_irq(done_irq)
  );

  // ---------------- coprocessor mailbox model ----------------
  logic [31:0] fw_status = 32'hF0;
  logic        fw_respond = 1'b1;
  int          busy_cfg = 0;
  logic        stuck = 1'b0;
  logic        stale = 1'b0;
  logic [31:0] fw_rd [4];

  logic [31:0] st_reg = '0;
  logic [31:0] prm [4];
  int          cd = 0;
  int          poll_seen = 0;
  int          nz_reads = 0;
  int          wr_cnt = 0;
  int          db_cnt = 0;
  int          db_cyc = 0;
  int          cyc = 0;
  int          lg_n = 0;
  logic        lg_we  [512];
  logic        lg_sel [512];
  logic [7:0]  lg_addr[512];
  logic [31:0] lg_data[512];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (doorbell) begin
      db_cnt <= db_cnt + 1;
      db_cyc <= cyc;
    end
    done_irq <= 1'b0;
    if (cd > 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        st_reg <= fw_status;
        for (int k = 0; k < 4; k++) prm[k] <= fw_rd[k];
        done_irq <= 1'b1;
      end
    end
    if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        wr_cnt <= wr_cnt + 1;
        lg_we[lg_n] <= 1'b1; lg_sel[lg_n] <= bus_sel;
        lg_addr[lg_n] <= bus_addr; lg_data[lg_n] <= bus_wdata;
        lg_n <= lg_n + 1;
        if (bus_sel) begin
          poll_seen <= 0;
          if (fw_respond) cd <= DELAY;
        end else if (bus_addr == 8'h04) begin
          st_reg <= bus_wdata;
        end else if (bus_addr >= 8'h18 && bus_addr <= 8'h24) begin
          prm[(bus_addr - 8'h18) >> 2] <= bus_wdata;
        end
      end else if (!bus_sel && bus_addr == 8'h00 && (stuck || poll_seen < busy_cfg)) begin
        bus_rdata <= 32'd1;
        if (stale && poll_seen == 0) done_irq <= 1'b1;
        poll_seen <= poll_seen + 1;
        nz_reads  <= nz_reads + 1;
      end else begin
        logic [31:0] rv;
        if (bus_addr == 8'h04) rv = st_reg;
        else if (bus_addr >= 8'h18 && bus_addr <= 8'h24) rv = prm[(bus_addr - 8'h18) >> 2];
        else rv = 32'd0;
        bus_rdata <= rv;
        lg_we[lg_n] <= 1'b0; lg_sel[lg_n] <= bus_sel;
        lg_addr[lg_n] <= bus_addr; lg_data[lg_n] <= rv;
        lg_n <= lg_n + 1;
      end
    end
  end

  // ---------------- checking ----------------
  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_op(input int pos, input bit we, input bit sel, input logic [7:0] addr,
                        input logic [31:0] data, input string tag);
    logic [63:0] a, e;
    a = {22'd0, lg_we[pos], lg_sel[pos], lg_addr[pos], lg_data[pos]};
    e = {22'd0, we, sel, addr, data};
    chk(pos < lg_n && a == e, tag, $sformatf("access #%0d", pos), a, e);
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input logic send, input logic has,
                         input logic [127:0] args, output logic [2:0] err,
                         output logic [127:0] rargs, output int elapsed, output int ready_bad);
    @(negedge clk);
    req_cmd = cmd; req_send = send; req_has_args = has; req_args = args;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ready_bad = 0;
    while (!rsp_valid) begin
      if (req_ready) ready_bad++;
      @(negedge clk);
    end
    err = rsp_err;
    rargs = rsp_args;
    elapsed = cyc - db_cyc;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after response", 64'(req_ready), 64'd1);
  endtask

  typedef struct packed {
    logic [7:0]  cmd;
    logic        send;
    logic        has;
    logic [31:0] st;
    logic [2:0]  err;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h41, 1'b1, 1'b1, 32'h0000_00F0, 3'd0},
    '{8'h31, 1'b1, 1'b1, 32'h0000_00F1, 3'd3},
    '{8'h30, 1'b0, 1'b1, 32'h0000_00F2, 3'd4},
    '{8'h40, 1'b0, 1'b1, 32'h0000_00F3, 3'd5},
    '{8'h31, 1'b1, 1'b1, 32'h0000_00F4, 3'd6},
    '{8'h11, 1'b1, 1'b0, 32'h0000_00FF, 3'd7},
    '{8'h12, 1'b0, 1'b0, 32'h0000_0037, 3'd0},
    '{8'h30, 1'b0, 1'b1, 32'h0000_00F0, 3'd0},
    '{8'h41, 1'b1, 1'b1, 32'h0000_0000, 3'd2},
    '{8'h40, 1'b0, 1'b1, 32'h0000_0100, 3'd2}
  };

  initial begin
    logic [2:0]   err;
    logic [127:0] rargs, args;
    int           el, rb, base, p, db0, nz0, wr0;

    for (int k = 0; k < 4; k++) begin fw_rd[k] = '0; prm[k] = '0; end
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1, "R10", "reset req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(bus_req == 1'b0 && doorbell == 1'b0, "R5", "reset bus_req/doorbell",
        64'({bus_req, doorbell}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_req == 1'b0, "R10", "idle after reset",
        64'({req_ready, bus_req}), 64'd2);

    // R4: offset folding
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ex;
      ex = (i < 4) ? 8'(8'h18 + 4 * i) : 8'h18;
      chk(mbx_pkg::arg_offset(3'(i)) == ex, "R4", $sformatf("offset idx %0d", i),
          64'(mbx_pkg::arg_offset(3'(i))), 64'(ex));
    end

    // Vector table
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      bit   usable;
      v = VECS[i];
      fw_status = v.st;
      fw_respond = 1'b1;
      for (int k = 0; k < 4; k++) begin
        fw_rd[k] = 32'h5000_0000 + 32'(i * 16 + k);
        args[k*32 +: 32] = 32'hA000_0000 + 32'(i * 16 + k);
      end
      base = lg_n; db0 = db_cnt;
      run_cmd(v.cmd, v.send, v.has, args, err, rargs, el, rb);
      usable = (v.err != 3'd2);
      p = base;
      chk_op(p, 1'b0, 1'b0, 8'h00, 32'h0, "R1"); p++;
      chk_op(p, 1'b1, 1'b0, 8'h04, 32'h0, "R2"); p++;
      if (v.send && v.has)
        for (int k = 0; k < 4; k++) begin
          chk_op(p, 1'b1, 1'b0, 8'(8'h18 + 4 * k), args[k*32 +: 32], "R3"); p++;
        end
      chk_op(p, 1'b1, 1'b0, 8'h00, 32'(v.cmd), "R5"); p++;
      chk_op(p, 1'b1, 1'b1, 8'h04, 32'h8000_0000, "R5"); p++;
      chk_op(p, 1'b0, 1'b0, 8'h04, v.st, "R7"); p++;
      if (usable && !v.send && v.has) begin
        for (int k = 0; k < 4; k++) begin
          chk_op(p, 1'b0, 1'b0, 8'(8'h18 + 4 * k), fw_rd[k], "R8"); p++;
          chk(rargs[k*32 +: 32] == fw_rd[k], "R8", $sformatf("rsp arg %0d", k),
              64'(rargs[k*32 +: 32]), 64'(fw_rd[k]));
        end
      end
      if (usable) begin chk_op(p, 1'b1, 1'b0, 8'h04, 32'h0, "R8"); p++; end
      chk(lg_n == p, "R3", $sformatf("row %0d access count", i), 64'(lg_n - base), 64'(p - base));
      chk(err == v.err, usable ? "R9" : "R7", $sformatf("row %0d error code", i), 64'(err), 64'(v.err));
      chk(db_cnt - db0 == 1, "R5", "one doorbell", 64'(db_cnt - db0), 64'd1);
      chk(rb == 0, "R10", "ready low while busy", 64'(rb), 64'd0);
    end

    // R1: three busy reads then idle
    busy_cfg = 3; fw_status = 32'hF0; fw_respond = 1'b1;
    nz0 = nz_reads;
    run_cmd(8'h41, 1'b1, 1'b0, '0, err, rargs, el, rb);
    chk(nz_reads - nz0 == 3, "R1", "busy reads before idle", 64'(nz_reads - nz0), 64'd3);
    chk(err == 3'd0, "R1", "ok after busy wait", 64'(err), 64'd0);

    // R1: stuck busy
    stuck = 1'b1; nz0 = nz_reads; wr0 = wr_cnt; db0 = db_cnt;
    run_cmd(8'h41, 1'b1, 1'b1, '1, err, rargs, el, rb);
    chk(err == 3'd1, "R1", "stuck busy code", 64'(err), 64'd1);
    chk(nz_reads - nz0 == PLIMIT, "R1", "poll read count", 64'(nz_reads - nz0), 64'(PLIMIT));
    chk(wr_cnt == wr0 && db_cnt == db0, "R1", "no write when busy",
        64'(wr_cnt - wr0), 64'd0);
    stuck = 1'b0; busy_cfg = 0;

    // R7: no completion at all
    fw_respond = 1'b0; base = lg_n;
    run_cmd(8'h40, 1'b0, 1'b1, '0, err, rargs, el, rb);
    chk(err == 3'd2, "R7", "silent timeout code", 64'(err), 64'd2);
    chk(el >= TMO, "R7", "waited full window", 64'(el), 64'(TMO));
    chk(lg_n > 0 && lg_we[lg_n-1] == 1'b0 && lg_addr[lg_n-1] == 8'h04, "R7",
        "status read is last access, no clear", 64'({lg_we[lg_n-1], lg_addr[lg_n-1]}), 64'h04);

    // R6: completion edge during the poll must be discarded
    busy_cfg = 2; stale = 1'b1; fw_respond = 1'b0;
    run_cmd(8'h41, 1'b1, 1'b0, '0, err, rargs, el, rb);
    chk(err == 3'd2, "R6", "stale edge still times out", 64'(err), 64'd2);
    chk(el >= TMO, "R6", "stale edge did not end wait", 64'(el), 64'(TMO));
    stale = 1'b0; busy_cfg = 0; fw_respond = 1'b1;

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done_flag) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule